// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block is the retirement buffer of a single-issue core that executes out of order. The dispatch stage claims one slot per instruction in program order and receives a small tag. The execution side then marks slots finished, in any order, through a single writeback port: one result per cycle, matching the one register-file write port. Each slot holds the destination register, the result value, a finished flag and a vector of synchronous fault flags.

The oldest slot retires when it is finished. A clean result is presented on the register-file write port for that cycle and the slot is released. At most one slot retires per cycle. A finished slot that is younger than an unfinished one waits. When the oldest slot finishes with any fault flag set, the buffer raises an exception with a cause code instead of writing the register. A fixed priority picks the cause when several faults are set. On the following clock edge every slot is discarded and the pointers restart at zero.

Top module: `retire_queue`

## Requirements
- R1: After a synchronous active-high reset the buffer is empty: `alloc_ready` is 1, `commit_valid` is 0 and `exc_valid` is 0.
- R2: Accepted allocations receive consecutive tags in allocation order, wrapping from DEPTH-1 (15 by default) to 0.
- R3: At most DEPTH (16) slots are outstanding. With all slots occupied and no retirement in the same cycle, `alloc_ready` is 0 and a request is not accepted.
- R4: Only the oldest slot retires. A finished younger slot is held while any older slot is unfinished, and slots retire in allocation order.
- R5: A clean writeback to the oldest slot on one clock edge makes `commit_valid` 1 during the next cycle. In that cycle `commit_dest`, `commit_data` and `commit_tag` show that slot's register, written value and tag.
- R6: At most one slot retires per cycle: `commit_valid` and `exc_valid` are never 1 together, and each retirement releases exactly one slot.
- R7: With all slots occupied, a request made in the cycle the oldest slot retires is accepted. It receives the tag just released.
- R8: When the oldest slot is finished with a non-zero fault vector, `exc_valid` is 1, `exc_tag` is its tag, `exc_cause` is non-zero and `commit_valid` is 0.
- R9: Fault vector bits are bit0 invalid opcode, bit1 divide by zero, bit2 misaligned access and bit3 arithmetic overflow. `exc_cause` is the lowest set bit index plus one, so invalid opcode (1) wins over divide by zero (2), which wins over misaligned (3), which wins over overflow (4).
- R10: On the clock edge that ends an exception cycle, all slots are discarded. Younger slots never retire, and the next accepted allocation receives tag 0.
- R11: A writeback naming a tag that holds no outstanding slot has no effect. A slot allocated later at that tag is not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_dest | input | 5 | Destination register of the dispatched instruction |
| alloc_ready | output | 1 | A request this cycle is accepted |
| alloc_tag | output | TAG_W (4) | Tag given to the slot claimed this cycle |
| wb_valid | input | 1 | A result is being written back |
| wb_tag | input | TAG_W (4) | Tag of the slot being marked finished |
| wb_data | input | 32 | Result value |
| wb_fault | input | 4 | Fault flags raised by the instruction |
| commit_valid | output | 1 | Register-file write enable for the retiring slot |
| commit_dest | output | 5 | Register written at retirement |
| commit_data | output | 32 | Value written at retirement |
| commit_tag | output | TAG_W (4) | Tag of the retiring slot |
| exc_valid | output | 1 | Oldest slot faulted; buffer flushes next edge |
| exc_cause | output | 3 | Prioritised cause code |
| exc_tag | output | TAG_W (4) | Tag of the faulting slot |

## Verification
A wrong head pointer or a stale finished flag shows up at the register-file port. It appears as a retirement with the wrong tag, register or value, in the first cycle that the bench expects a retirement. A miscounted occupancy shows up in `alloc_ready` on the one cycle where the buffer reaches full or a refused request turns into an accepted one. A flush that leaves a slot behind shows up in the next allocation, which gets a tag other than 0. It also shows up as a spurious retirement of a discarded younger slot within a cycle or two. The scoreboard pairs every retirement and exception with the item the bench pushed when it allocated, so any order error is reported on the same cycle it happens.

// File: rtl/retq_pkg.sv
package retq_pkg;

    localparam int DATA_W  = 32;
    localparam int DEST_W  = 5;
    localparam int FAULT_N = 4;
    localparam int CAUSE_W = 3;

    // Fault vector bit positions; a lower index has higher priority.
    localparam int F_BAD_OPCODE = 0;
    localparam int F_DIV_ZERO   = 1;
    localparam int F_MISALIGN   = 2;
    localparam int F_OVERFLOW   = 3;

    typedef logic [FAULT_N-1:0] fault_t;
    typedef logic [CAUSE_W-1:0] cause_t;

    typedef struct packed {
        logic              valid;
        logic              done;
        logic [DEST_W-1:0] dest;
        logic [DATA_W-1:0] data;
        fault_t            fault;
    } slot_t;

    // Lowest set bit wins; the result is index + 1, 0 when no bit is set.
    function automatic cause_t fault_to_cause(input fault_t f);
        cause_t c;
        c = '0;
        for (int i = FAULT_N - 1; i >= 0; i--) begin
            if (f[i]) begin
                c = cause_t'(i + 1);
            end
        end
        return c;
    endfunction

endpackage

// File: rtl/retq_ptrs.sv
module retq_ptrs #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic             clear,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + IDX_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                tail <= step(tail);
            end
            if (pop) begin
                head <= step(head);
            end
            case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    assign full = (count == CNT_MAX);

    // R3: a push into a full buffer is only legal when a pop frees a slot.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        !(push && full && !pop));

    // R6: a retirement never happens from an empty buffer.
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> (count != '0));

endmodule

// File: rtl/retq_slots.sv
module retq_slots
    import retq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              alloc_en,
    input  logic [IDX_W-1:0]  alloc_idx,
    input  logic [DEST_W-1:0] alloc_dest,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  fault_t            wb_fault,
    input  logic              pop,
    input  logic [IDX_W-1:0]  head_idx,
    output slot_t             head_slot
);

    slot_t slot_view [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        slot_t s_q;
        logic  hit_alloc;
        logic  hit_wb;
        logic  hit_pop;

        assign hit_alloc = alloc_en && (alloc_idx == IDX_W'(g));
        assign hit_wb    = wb_en && (wb_idx == IDX_W'(g));
        assign hit_pop   = pop && (head_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                s_q <= '0;
            end else begin
                if (hit_pop) begin
                    s_q.valid <= 1'b0;
                end
                if (hit_alloc) begin
                    s_q.valid <= 1'b1;
                    s_q.done  <= 1'b0;
                    s_q.dest  <= alloc_dest;
                    s_q.fault <= '0;
                end else if (hit_wb && s_q.valid && !s_q.done) begin
                    s_q.done  <= 1'b1;
                    s_q.data  <= wb_data;
                    s_q.fault <= wb_fault;
                end
            end
        end

        assign slot_view[g] = s_q;
    end

    assign head_slot = slot_view[head_idx];

    // R4: only a finished, clean oldest slot is released.
    p_pop_ready_head_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> (head_slot.valid && head_slot.done && (head_slot.fault == '0)));

endmodule

// File: rtl/retq_retire.sv
module retq_retire
    import retq_pkg::*;
(
    input  slot_t  head_slot,
    output logic   commit_valid,
    output logic   exc_valid,
    output cause_t cause
);

    logic head_finished;
    logic head_faulted;

    assign head_finished = head_slot.valid && head_slot.done;
    assign head_faulted  = |head_slot.fault;

    always_comb begin
        commit_valid = head_finished && !head_faulted;
        exc_valid    = head_finished && head_faulted;
        cause        = exc_valid ? fault_to_cause(head_slot.fault) : '0;
    end

endmodule

// File: rtl/retire_queue.sv
module retire_queue
    import retq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_valid,
    input  logic [DEST_W-1:0] alloc_dest,
    output logic              alloc_ready,
    output logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [FAULT_N-1:0] wb_fault,
    output logic              commit_valid,
    output logic [DEST_W-1:0] commit_dest,
    output logic [DATA_W-1:0] commit_data,
    output logic [TAG_W-1:0]  commit_tag,
    output logic              exc_valid,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [TAG_W-1:0]  exc_tag
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(DEPTH - 1);

    logic [TAG_W-1:0] head;
    logic [TAG_W-1:0] tail;
    logic [CNT_W-1:0] count;
    logic             full;
    logic             alloc_fire;
    logic             wb_en;
    slot_t            head_slot;
    cause_t           cause;

    assign alloc_ready = !exc_valid && (!full || commit_valid);
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign wb_en       = wb_valid && !exc_valid;

    retq_ptrs #(
        .DEPTH (DEPTH),
        .IDX_W (TAG_W),
        .CNT_W (CNT_W)
    ) u_ptrs (
        .clk   (clk),
        .rst   (rst),
        .push  (alloc_fire),
        .pop   (commit_valid),
        .clear (exc_valid),
        .head  (head),
        .tail  (tail),
        .count (count),
        .full  (full)
    );

    retq_slots #(
        .DEPTH (DEPTH),
        .IDX_W (TAG_W)
    ) u_slots (
        .clk        (clk),
        .rst        (rst),
        .clear      (exc_valid),
        .alloc_en   (alloc_fire),
        .alloc_idx  (tail),
        .alloc_dest (alloc_dest),
        .wb_en      (wb_en),
        .wb_idx     (wb_tag),
        .wb_data    (wb_data),
        .wb_fault   (wb_fault),
        .pop        (commit_valid),
        .head_idx   (head),
        .head_slot  (head_slot)
    );

    retq_retire u_retire (
        .head_slot    (head_slot),
        .commit_valid (commit_valid),
        .exc_valid    (exc_valid),
        .cause        (cause)
    );

    assign alloc_tag   = tail;
    assign commit_dest = head_slot.dest;
    assign commit_data = head_slot.data;
    assign commit_tag  = head;
    assign exc_cause   = cause;
    assign exc_tag     = head;

    // R2: consecutive accepted allocations get consecutive, wrapping tags.
    p_tag_step_r2: assert property (@(posedge clk) disable iff (rst)
        alloc_fire |=> (alloc_tag == (($past(alloc_tag) == LAST_TAG) ?
                                      '0 : $past(alloc_tag) + TAG_W'(1))));

    // R10: an exception cycle leaves the buffer empty on the next cycle.
    p_flush_empties_r10: assert property (@(posedge clk) disable iff (rst)
        exc_valid |=> ((count == '0) && !commit_valid && !exc_valid));

    // R9: an invalid-opcode flag always reports cause 1.
    p_opcode_first_r9: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && head_slot.fault[F_BAD_OPCODE]) |-> (exc_cause == 3'd1));

    // R8: a reported exception carries a non-zero cause and writes nothing.
    p_exc_cause_r8: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> ((exc_cause != '0) && !commit_valid));

endmodule

// File: tb/retire_queue_test.sv
module retire_queue_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        alloc_valid;
    logic [4:0]  alloc_dest;
    logic        alloc_ready;
    logic [3:0]  alloc_tag;
    logic        wb_valid;
    logic [3:0]  wb_tag;
    logic [31:0] wb_data;
    logic [3:0]  wb_fault;
    logic        commit_valid;
    logic [4:0]  commit_dest;
    logic [31:0] commit_data;
    logic [3:0]  commit_tag;
    logic        exc_valid;
    logic [2:0]  exc_cause;
    logic [3:0]  exc_tag;

    always #4 clk = ~clk;

    retire_queue uut (
        .clk          (clk),
        .rst          (rst),
        .alloc_valid  (alloc_valid),
        .alloc_dest   (alloc_dest),
        .alloc_ready  (alloc_ready),
        .alloc_tag    (alloc_tag),
        .wb_valid     (wb_valid),
        .wb_tag       (wb_tag),
        .wb_data      (wb_data),
        .wb_fault     (wb_fault),
        .commit_valid (commit_valid),
        .commit_dest  (commit_dest),
        .commit_data  (commit_data),
        .commit_tag   (commit_tag),
        .exc_valid    (exc_valid),
        .exc_cause    (exc_cause),
        .exc_tag      (exc_tag)
    );

    typedef struct packed {
        logic        exc;
        logic [2:0]  cause;
        logic [4:0]  dest;
        logic [31:0] data;
        logic [3:0]  tag;
    } exp_t;

    exp_t        q[$];
    int          total = 0;
    int          fails = 0;
    logic [3:0]  next_tag = '0;
    logic [31:0] dat [16];
    logic        done_flag = 1'b0;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    // Monitor: every retirement or exception is matched against the queue.
    always @(negedge clk) begin
        if (!rst && (commit_valid || exc_valid)) begin
            chk("R6", "single retire event", 64'(commit_valid && exc_valid), 64'd0);
            if (q.size() == 0) begin
                chk("R4", "unexpected retirement", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (e.exc) begin
                    chk("R8", "exc_valid", 64'(exc_valid), 64'd1);
                    chk("R8", "exc_tag", 64'(exc_tag), 64'(e.tag));
                    chk("R9", "exc_cause", 64'(exc_cause), 64'(e.cause));
                    if (exc_valid) begin
                        next_tag = '0;
                    end
                end else begin
                    chk("R4", "commit_valid", 64'(commit_valid), 64'd1);
                    chk("R5", "commit_tag", 64'(commit_tag), 64'(e.tag));
                    chk("R5", "commit_dest", 64'(commit_dest), 64'(e.dest));
                    chk("R5", "commit_data", 64'(commit_data), 64'(e.data));
                end
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic alloc(input logic [4:0] dest, input logic push,
                         input logic exp_ready, input logic exc,
                         input logic [2:0] cause, input logic [31:0] data,
                         input string req, output logic [3:0] tag);
        exp_t e;
        alloc_valid = 1'b1;
        alloc_dest  = dest;
        tag         = 'x;
        @(negedge clk);
        chk(req, "alloc_ready", 64'(alloc_ready), 64'(exp_ready));
        if (alloc_ready) begin
            chk("R2", "alloc_tag", 64'(alloc_tag), 64'(next_tag));
            tag      = alloc_tag;
            dat[tag] = data;
            if (push) begin
                e.exc   = exc;
                e.cause = cause;
                e.dest  = dest;
                e.data  = data;
                e.tag   = alloc_tag;
                q.push_back(e);
            end
            next_tag = next_tag + 4'd1;
        end
        @(posedge clk);
        #1;
        alloc_valid = 1'b0;
    endtask

    task automatic wb(input logic [3:0] tag, input logic [31:0] data,
                      input logic [3:0] fault);
        wb_valid = 1'b1;
        wb_tag   = tag;
        wb_data  = data;
        wb_fault = fault;
        @(posedge clk);
        #1;
        wb_valid = 1'b0;
        wb_fault = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic [3:0] t;
        logic [3:0] ta;
        logic [3:0] tb;
        logic [3:0] tc;
        logic [3:0] flt [3];
        logic [2:0] cau [3];

        rst         = 1'b1;
        alloc_valid = 1'b0;
        alloc_dest  = '0;
        wb_valid    = 1'b0;
        wb_tag      = '0;
        wb_data     = '0;
        wb_fault    = '0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        chk("R1", "alloc_ready", 64'(alloc_ready), 64'd1);
        chk("R1", "commit_valid", 64'(commit_valid), 64'd0);
        chk("R1", "exc_valid", 64'(exc_valid), 64'd0);
        @(posedge clk);
        #1;

        // R4/R5: four slots finished in reverse order retire in order
        for (int i = 0; i < 4; i++) begin
            alloc(5'(i + 1), 1'b1, 1'b1, 1'b0, 3'd0, 32'hA000_0000 + 32'(i), "R2", t);
        end
        for (int i = 3; i >= 1; i--) begin
            wb(4'(i), dat[i], 4'h0);
        end
        @(negedge clk);
        chk("R4", "younger finished slots wait", 64'(commit_valid), 64'd0);
        @(posedge clk);
        #1;
        wb(4'd0, dat[0], 4'h0);
        idle(6);

        // R3/R7: fill all 16 slots, refuse, then allocate during retirement
        for (int i = 0; i < 16; i++) begin
            alloc(5'(i + 8), 1'b1, 1'b1, 1'b0, 3'd0, 32'hB000_0000 + 32'(i), "R3", t);
        end
        alloc(5'd30, 1'b1, 1'b0, 1'b0, 3'd0, 32'hDEAD_0000, "R3", t);
        wb(4'd4, dat[4], 4'h0);
        alloc(5'd31, 1'b1, 1'b1, 1'b0, 3'd0, 32'hC000_0001, "R7", t);
        chk("R7", "tag reused at full", 64'(t), 64'd4);
        for (int k = 0; k < 15; k++) begin
            logic [3:0] wt;
            wt = 4'((5 + ((k * 7) % 15)) % 16);
            wb(wt, dat[wt], 4'h0);
        end
        wb(4'd4, dat[4], 4'h0);
        idle(20);

        // R11: writeback to an empty tag, then allocate there
        t = next_tag;
        wb(t, 32'h5555_AAAA, 4'h0);
        alloc(5'd7, 1'b1, 1'b1, 1'b0, 3'd0, 32'hD000_0007, "R11", t);
        @(negedge clk);
        chk("R11", "stale writeback ignored", 64'(commit_valid), 64'd0);
        @(posedge clk);
        #1;
        wb(t, dat[t], 4'h0);
        idle(3);

        // R8/R9/R10: faulting oldest slot flushes younger finished slots
        alloc(5'd9, 1'b1, 1'b1, 1'b1, 3'd1, 32'hE000_0000, "R8", ta);
        alloc(5'd10, 1'b0, 1'b1, 1'b0, 3'd0, 32'hE000_0001, "R8", tb);
        alloc(5'd11, 1'b0, 1'b1, 1'b0, 3'd0, 32'hE000_0002, "R8", tc);
        wb(tc, dat[tc], 4'h0);
        wb(tb, dat[tb], 4'h0);
        wb(ta, dat[ta], 4'b0011);
        idle(3);
        @(negedge clk);
        chk("R10", "no retirement after flush", 64'(commit_valid), 64'd0);
        chk("R10", "tag restarts", 64'(alloc_tag), 64'd0);
        @(posedge clk);
        #1;

        // R9: remaining priority pairs
        flt[0] = 4'b0110; cau[0] = 3'd2;
        flt[1] = 4'b1100; cau[1] = 3'd3;
        flt[2] = 4'b1000; cau[2] = 3'd4;
        for (int i = 0; i < 3; i++) begin
            alloc(5'd12, 1'b1, 1'b1, 1'b1, cau[i], 32'hF000_0000, "R9", t);
            chk("R10", "tag after flush", 64'(t), 64'd0);
            wb(t, dat[t], flt[i]);
            idle(2);
        end

        // R4/R8: clean older slot retires before a faulting younger one
        alloc(5'd13, 1'b1, 1'b1, 1'b0, 3'd0, 32'h1234_5678, "R4", ta);
        alloc(5'd14, 1'b1, 1'b1, 1'b1, 3'd2, 32'h0, "R8", tb);
        wb(tb, 32'h0, 4'b0110);
        wb(ta, dat[ta], 4'h0);
        idle(5);

        chk("R4", "all expected retirements seen", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule